// File: doc/BRIEF.md
# Periodic Timebase Interrupt Generator

This block produces a steady train of interrupt events from a single input clock. A binary divider chain of fifteen stages counts the input clock. A static strap can place a fixed divide-by-128 prescaler ahead of the chain. A 3-bit rate select picks one of eight chain bits as the event tap, which gives division ratios from 8 up to 32768. The ratios are not evenly spaced: every power of two from 8 to 128, then 2048, 8192 and 32768.

Software sets the run enable, picks a rate and, if it wants the interrupt line, sets the interrupt enable. Each time the selected tap bit goes from 0 to 1, a sticky status flag is set. Software clears the flag by writing a 1 through the acknowledge strobe. The chain starts from zero, so the first event after enable comes at half the selected period. Every later event comes one full period after the previous one.

A stop request freezes the block unless the oscillator-in-stop option is set. With that option set, the block keeps counting through stop and can serve as a periodic wake-up source.

Top module: `tbase_irq_gen`

## Requirements
- R1: After reset, `status_flag` and `irq_req` are both 0.
- R2: While `run_en` is 0, the prescaler and the divider chain are held at zero. After `run_en` is set again, timing restarts from zero, so earlier progress is discarded.
- R3: The rate select encoding is 000=32768, 001=8192, 010=2048, 011=128, 100=64, 101=32, 110=16, 111=8. Take the ratio N selected this way. With the strap clear, the first flag set after enable happens on the N/2-th counting clock edge.
- R4: After the first event, each following event comes exactly N counting clock edges after the previous one.
- R5: When `pre128_strap` is 1, every ratio is multiplied by 128: the first event comes after 64*N counting edges and later events every 128*N.
- R6: A clock edge with `ack_wr`=1 and `ack_val`=1 clears `status_flag`. A write with `ack_val`=0 leaves the flag unchanged, and the flag otherwise stays set.
- R7: When a tap event and a clearing acknowledge fall on the same edge, the flag ends up set.
- R8: `irq_req` is high exactly when `status_flag` and `irq_en` are both high. It follows `irq_en` in the same cycle, with no clock delay.
- R9: While `stop_req` is 1 and `osc_in_stop` is 0, counting is frozen. No event occurs, and counting resumes from the frozen value when stop ends.
- R10: While `stop_req` is 1 and `osc_in_stop` is 1, counting and events continue unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that the divider counts |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre128_strap | input | 1 | Static strap: 1 inserts the divide-by-128 prescaler |
| run_en | input | 1 | Module enable; 0 holds all counters at zero |
| rate_sel | input | 3 | Tap select code (see R3) |
| irq_en | input | 1 | Interrupt enable |
| ack_wr | input | 1 | Acknowledge write strobe |
| ack_val | input | 1 | Data bit of the acknowledge write; 1 clears the flag |
| stop_req | input | 1 | System stop mode active |
| osc_in_stop | input | 1 | Configuration: the oscillator keeps running in stop |
| status_flag | output | 1 | Sticky event flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The bound checker watches the local rules on every cycle:
- a flag can rise only after a tap event;
- a tap event always sets the flag, even against an acknowledge;
- the flag stays set until a clearing write;
- the chain is zero after a disabled cycle and does not move while frozen in stop;
- the interrupt line never rises without both flag and enable.

The actual event spacing can only be shown by the bench's scenarios. That includes the half-period first event, the full period after it, the factor of 128 from the strap, and the restart after re-enable. The bench's behavioural model counts clock edges and compares flag and interrupt on every cycle. Timed runs also measure the distance between events for every rate code.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  localparam int TAP_IDX_W = 4;
  localparam int SEL_W     = 3;

  typedef enum logic [SEL_W-1:0] {
    RATE_32768 = 3'b000,
    RATE_8192  = 3'b001,
    RATE_2048  = 3'b010,
    RATE_128   = 3'b011,
    RATE_64    = 3'b100,
    RATE_32    = 3'b101,
    RATE_16    = 3'b110,
    RATE_8     = 3'b111
  } rate_sel_e;

  // Chain bit whose 0->1 transition marks an event: log2(ratio) - 1.
  function automatic logic [TAP_IDX_W-1:0] tap_index(input rate_sel_e sel);
    logic [TAP_IDX_W-1:0] idx;
    unique case (sel)
      RATE_32768: idx = 4'd14;
      RATE_8192:  idx = 4'd12;
      RATE_2048:  idx = 4'd10;
      RATE_128:   idx = 4'd6;
      RATE_64:    idx = 4'd5;
      RATE_32:    idx = 4'd4;
      RATE_16:    idx = 4'd3;
      default:    idx = 4'd2;
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic adv,
  input  logic use_pre,
  output logic tick
);

  localparam logic [PRE_W-1:0] PRE_ONE = {{(PRE_W-1){1'b0}}, 1'b1};

  logic [PRE_W-1:0] pre_q;
  logic             pre_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (!run_en || !use_pre) begin
      pre_q <= '0;
    end else if (adv) begin
      pre_q <= pre_q + PRE_ONE;
    end
  end

  assign pre_full = &pre_q;
  assign tick     = adv & (~use_pre | pre_full);

endmodule

// File: rtl/tbase_divchain.sv
module tbase_divchain
  import tbase_pkg::*;
#(
  parameter int CHAIN_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               tick,
  input  logic [SEL_W-1:0]   rate_sel,
  output logic [CHAIN_W-1:0] chain_q,
  output logic               tap_event
);

  localparam logic [CHAIN_W-1:0] CH_ONE = {{(CHAIN_W-1){1'b0}}, 1'b1};

  logic [CHAIN_W-1:0]   rise;
  logic [TAP_IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (!run_en) begin
      chain_q <= '0;
    end else if (tick) begin
      chain_q <= chain_q + CH_ONE;
    end
  end

  // Per-bit rising transition on the coming increment.
  generate
    for (genvar i = 0; i < CHAIN_W; i++) begin : g_rise
      if (i == 0) begin : g_lsb
        assign rise[i] = tick & ~chain_q[0];
      end else begin : g_upper
        assign rise[i] = tick & ~chain_q[i] & (&chain_q[i-1:0]);
      end
    end
  endgenerate

  assign idx       = tap_index(rate_sel_e'(rate_sel));
  assign tap_event = rise[idx];

endmodule

// File: rtl/tbase_flag.sv
module tbase_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic ack_wr,
  input  logic ack_val,
  input  logic irq_en,
  output logic flag_q,
  output logic irq
);

  logic clr_req;

  assign clr_req = ack_wr & ack_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (set_evt) begin
      flag_q <= 1'b1;
    end else if (clr_req) begin
      flag_q <= 1'b0;
    end
  end

  assign irq = flag_q & irq_en;

endmodule

// File: rtl/tbase_irq_gen.sv
module tbase_irq_gen
  import tbase_pkg::*;
#(
  parameter int CHAIN_W = 15,
  parameter int PRE_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre128_strap,
  input  logic             run_en,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             irq_en,
  input  logic             ack_wr,
  input  logic             ack_val,
  input  logic             stop_req,
  input  logic             osc_in_stop,
  output logic             status_flag,
  output logic             irq_req
);

  logic               adv_w;
  logic               tick_w;
  logic               tap_event_w;
  logic [CHAIN_W-1:0] chain_q_w;

  // Counting is allowed when not stopped, or when the oscillator runs in stop.
  assign adv_w = run_en & (~stop_req | osc_in_stop);

  tbase_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .adv     (adv_w),
    .use_pre (pre128_strap),
    .tick    (tick_w)
  );

  tbase_divchain #(.CHAIN_W(CHAIN_W)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .tick      (tick_w),
    .rate_sel  (rate_sel),
    .chain_q   (chain_q_w),
    .tap_event (tap_event_w)
  );

  tbase_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (tap_event_w),
    .ack_wr  (ack_wr),
    .ack_val (ack_val),
    .irq_en  (irq_en),
    .flag_q  (status_flag),
    .irq     (irq_req)
  );

endmodule

// File: rtl/tbase_irq_gen_chk.sv
module tbase_irq_gen_chk #(
  parameter int CHAIN_W = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run_en,
  input logic               stop_req,
  input logic               osc_in_stop,
  input logic               irq_en,
  input logic               ack_wr,
  input logic               ack_val,
  input logic               status_flag,
  input logic               irq_req,
  input logic               adv,
  input logic               tap_event,
  input logic [CHAIN_W-1:0] chain_q
);

  a_r2_chain_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (chain_q == '0));

  a_r3_rise_from_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_flag) |-> $past(tap_event));

  a_r4_event_needs_advance: assert property (@(posedge clk) disable iff (!rst_n)
    tap_event |-> adv);

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && ack_val && !tap_event) |=> !status_flag);

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_flag && !(ack_wr && ack_val)) |=> status_flag);

  a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tap_event |=> status_flag);

  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> status_flag);

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_req);

  a_r9_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && stop_req && !osc_in_stop) |=> $stable(chain_q));

  a_r10_stop_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && stop_req && osc_in_stop) |-> adv);

endmodule

bind tbase_irq_gen tbase_irq_gen_chk #(.CHAIN_W(CHAIN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_en      (run_en),
  .stop_req    (stop_req),
  .osc_in_stop (osc_in_stop),
  .irq_en      (irq_en),
  .ack_wr      (ack_wr),
  .ack_val     (ack_val),
  .status_flag (status_flag),
  .irq_req     (irq_req),
  .adv         (adv_w),
  .tap_event   (tap_event_w),
  .chain_q     (chain_q_w)
);

// File: tb/tbase_irq_gen_tb.sv
`timescale 1ns/1ps
module tbase_irq_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pre128_strap = 1'b0;
  logic       run_en = 1'b0;
  logic [2:0] rate_sel = 3'd7;
  logic       irq_en = 1'b0;
  logic       ack_wr = 1'b0;
  logic       ack_val = 1'b0;
  logic       stop_req = 1'b0;
  logic       osc_in_stop = 1'b0;
  logic       status_flag;
  logic       irq_req;

  int    n_checks = 0;
  int    n_errs   = 0;
  string phase    = "R1";
  bit    done     = 1'b0;

  always #4 clk = ~clk;

  tbase_irq_gen u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pre128_strap (pre128_strap),
    .run_en       (run_en),
    .rate_sel     (rate_sel),
    .irq_en       (irq_en),
    .ack_wr       (ack_wr),
    .ack_val      (ack_val),
    .stop_req     (stop_req),
    .osc_in_stop  (osc_in_stop),
    .status_flag  (status_flag),
    .irq_req      (irq_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ratio_of(input logic [2:0] s);
    int r;
    case (s)
      3'd0: r = 32768;
      3'd1: r = 8192;
      3'd2: r = 2048;
      3'd3: r = 128;
      3'd4: r = 64;
      3'd5: r = 32;
      3'd6: r = 16;
      default: r = 8;
    endcase
    return r;
  endfunction

  // Behavioural reference: count enabled clock edges, derive events arithmetically.
  int acc = 0;
  bit mflag = 1'b0;

  always @(posedge clk) begin
    bit ev;
    int n;
    ev = 1'b0;
    if (!rst_n) begin
      acc = 0;
      mflag = 1'b0;
    end else begin
      n = ratio_of(rate_sel);
      if (!run_en) begin
        acc = 0;
      end else if (!stop_req || osc_in_stop) begin
        acc++;
        if (pre128_strap)
          ev = (acc % 128 == 0) && (((acc / 128) % n) == n / 2);
        else
          ev = (acc % n) == (n / 2);
      end
      if (ev) mflag = 1'b1;
      else if (ack_wr && ack_val) mflag = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({phase, " flag vs model"}, int'(status_flag), int'(mflag));
      chk({phase, " R8 irq vs model"}, int'(irq_req), int'(mflag && irq_en));
    end
  end

  // Counts rising edges until the flag is seen, then schedules a clearing ack.
  task automatic time_event(output int cyc);
    cyc = 0;
    do begin
      @(posedge clk);
      cyc++;
      #2;
      ack_wr = 1'b0;
    end while (!status_flag && cyc < 70000);
    ack_wr  = 1'b1;
    ack_val = 1'b1;
  endtask

  task automatic restart(input logic [2:0] s, input logic strap);
    @(posedge clk); #1;
    run_en = 1'b0; ack_wr = 1'b0; rate_sel = s; pre128_strap = strap;
    @(posedge clk); #1;
    run_en = 1'b1;
  endtask

  initial begin
    #(8 * 190000);
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    int t;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 flag after reset", int'(status_flag), 0);
    chk("R1 irq after reset", int'(irq_req), 0);
    rst_n = 1'b1;

    // R3 / R4 / R8: fastest rate, interrupts enabled
    phase = "R3";
    irq_en = 1'b1;
    restart(3'd7, 1'b0);
    time_event(t);
    chk("R3 first event ratio 8", t, 4);
    chk("R8 irq with flag", int'(irq_req), 1);
    phase = "R4";
    time_event(t);
    chk("R4 period ratio 8", t, 8);

    // R3 / R4 over every rate code
    for (int s = 0; s < 8; s++) begin
      phase = "R3";
      restart(3'(s), 1'b0);
      time_event(t);
      chk($sformatf("R3 first event code %0d", s), t, ratio_of(3'(s)) / 2);
      phase = "R4";
      time_event(t);
      chk($sformatf("R4 period code %0d", s), t, ratio_of(3'(s)));
    end

    // R2: disable discards progress
    phase = "R2";
    restart(3'd7, 1'b0);
    repeat (3) @(posedge clk);
    #1; run_en = 1'b0;
    repeat (2) @(posedge clk);
    #1; run_en = 1'b1;
    time_event(t);
    chk("R2 restart from zero", t, 4);

    // R5: prescaler strap
    phase = "R5";
    restart(3'd7, 1'b1);
    time_event(t);
    chk("R5 first event with strap", t, 512);
    time_event(t);
    chk("R5 period with strap", t, 1024);
    restart(3'd6, 1'b1);
    time_event(t);
    chk("R5 first event code 6 with strap", t, 1024);

    // R6 / R8: acknowledge behaviour, irq gating
    phase = "R6";
    irq_en = 1'b0;
    restart(3'd7, 1'b0);
    t = 0;
    do begin @(posedge clk); t++; #2; end while (!status_flag && t < 100);
    chk("R8 irq low while disabled", int'(irq_req), 0);
    irq_en = 1'b1; #1;
    chk("R8 irq follows enable at once", int'(irq_req), 1);
    irq_en = 1'b0;
    ack_wr = 1'b1; ack_val = 1'b0;
    @(posedge clk); #2;
    chk("R6 zero write keeps flag", int'(status_flag), 1);
    ack_val = 1'b1;
    @(posedge clk); #2;
    chk("R6 one write clears flag", int'(status_flag), 0);
    ack_wr = 1'b0;

    // R7: set beats a simultaneous acknowledge
    phase = "R7";
    restart(3'd7, 1'b0);
    ack_wr = 1'b1; ack_val = 1'b1;
    t = 0;
    do begin @(posedge clk); t++; #2; end while (!status_flag && t < 100);
    chk("R7 set wins over ack", t, 4);
    @(posedge clk); #2;
    chk("R7 ack clears one cycle later", int'(status_flag), 0);
    ack_wr = 1'b0;

    // R9: stop without oscillator freezes
    phase = "R9";
    restart(3'd7, 1'b0);
    repeat (2) @(posedge clk);
    #1; stop_req = 1'b1; osc_in_stop = 1'b0;
    repeat (20) @(posedge clk);
    #2;
    chk("R9 no event during stop", int'(status_flag), 0);
    stop_req = 1'b0;
    time_event(t);
    chk("R9 resumes from frozen count", t, 2);

    // R10: stop with oscillator keeps running
    phase = "R10";
    restart(3'd7, 1'b0);
    stop_req = 1'b1; osc_in_stop = 1'b1;
    time_event(t);
    chk("R10 first event in stop", t, 4);
    time_event(t);
    chk("R10 period in stop", t, 8);
    @(posedge clk); #1;
    ack_wr = 1'b0; stop_req = 1'b0;
    repeat (2) @(posedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule